// File: doc/BRIEF.md
# Ethernet Controller Register Port

This block is the register front end that a host processor uses to control a simple Ethernet controller. It uses an indirect scheme with two host ports. A write to the address port picks one of four control registers. Reads and writes on the data port then reach the register that was picked. The DMA engine, the descriptor rings and the MAC datapath sit outside this block.

Register 0 is the command and status word. It holds the initialise, start and stop commands, the interrupt enable, the receiver-on and transmitter-on indicators, and a set of sticky event flags. Error and interrupt summary bits are derived from those flags. Register 1 holds the low half of the initialisation-block base address. Register 2 holds its high byte. Register 3 holds the bus-control bits.

The datapath reports events on a vector input, and each event sets a sticky flag. The host clears a flag by writing 1 to it. A stop command also clears every flag. The base address and the bus-control bits can be changed only while the controller is stopped.

Top module: `nic_csr_port`

## Requirements
- R1: Writing the address port (`host_port`=1) loads its low 2 bits as the register index, and this index is 0 after reset. A data-port write (`host_port`=0) updates the indexed register. `host_rdata` always shows the indexed register.
- R2: Register 1 stores 16 bits. Register 2 stores only its low 8 bits and reads 0 in bits 15:8. `init_base` equals {register 2 [7:0], register 1}.
- R3: Register 3 stores bits 2:0, which drive `bus_ctl`; its other bits read 0. Writing 0 to it clears all three bits.
- R4: A data-port write to register 1, 2 or 3 takes effect only while the stop bit (register 0 bit 2) is 1. Otherwise the write is ignored.
- R5: Register 0 has six sticky flags. Each is set by the `evt_set` bit at the same position: 14 (babble), 12 (lost frame, no receive buffer owned), 11 (memory error), 10 (receive done), 9 (transmit done) and 8 (initialisation done). All other `evt_set` bits are ignored.
- R6: A flag is cleared by writing 1 to its bit in register 0. Writing 0 leaves it unchanged. If an event sets the flag in the same cycle as the clearing write, the flag stays set.
- R7: Register 0 bit 15 is read-only. It equals the OR of flags 14, 12 and 11.
- R8: Register 0 bit 7 is read-only and equals the OR of all six flags. Bit 6 is the interrupt enable and takes the value of every register 0 write. `irq` = bit 7 AND bit 6.
- R9: A register 0 write with bit 2 set does the following: it sets the stop bit; it clears all flags and bits 6, 5, 4, 1 and 0; it overrides the other bits in the same write; and it overrides events in the same cycle.
- R10: A register 0 write with bit 0 set and bit 2 clear sets bit 0 and clears the stop bit. It also pulses `init_req` high for exactly one cycle.
- R11: A register 0 write with bit 1 set and bit 2 clear sets bits 1, 5 (receiver on) and 4 (transmitter on) and clears the stop bit. `rx_en` and `tx_en` follow bits 5 and 4. Writing 0 to bits 0 and 1 has no effect.
- R12: After reset, register 0 reads 0x0004, registers 1 to 3 read 0, and `irq` and `init_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_port | input | 1 | 1 = address port, 0 = data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the indexed register |
| evt_set | input | 16 | Event pulses from the datapath, by flag position |
| irq | output | 1 | Interrupt request |
| init_base | output | 24 | Initialisation-block base address |
| bus_ctl | output | 3 | Bus-control bits |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| init_req | output | 1 | One-cycle request to fetch the initialisation block |

## Verification
The bench builds the block with its default parameters: a 24-bit base address split 16/8 and three bus-control bits. With these values the bench can check two things. First, a full-width write to register 2 is truncated. Second, a well-known status word (0x90F3) is reproduced from an initialise-and-start sequence followed by a lost-frame event. The bench also checks the following cases:
- a clear collides with a set in the same cycle;
- stop collides with an event in the same cycle;
- a configuration write arrives while the controller is running;
- the enable is turned off while a flag is pending.

// File: rtl/nic_csr_pkg.sv
// Shared constants for the Ethernet controller register port.
// Assumes a 16-bit host data path and four registers.
package nic_csr_pkg;
    localparam int DATA_W  = 16;
    localparam int CSR_CNT = 4;
    localparam int SEL_W   = $clog2(CSR_CNT);

    // Register indices
    typedef enum logic [SEL_W-1:0] {
        CSR_CMD     = 2'd0,
        CSR_BASE_LO = 2'd1,
        CSR_BASE_HI = 2'd2,
        CSR_BUS     = 2'd3
    } csr_idx_e;

    // Register 0 bit positions (the host software decodes these)
    localparam int B_ERR   = 15;
    localparam int B_BABL  = 14;
    localparam int B_LOST  = 12;
    localparam int B_MERR  = 11;
    localparam int B_RXD   = 10;
    localparam int B_TXD   = 9;
    localparam int B_IDONE = 8;
    localparam int B_INTR  = 7;
    localparam int B_IEN   = 6;
    localparam int B_RXON  = 5;
    localparam int B_TXON  = 4;
    localparam int B_STOP  = 2;
    localparam int B_STRT  = 1;
    localparam int B_INIT  = 0;

    localparam logic [DATA_W-1:0] FLAG_MASK = 16'h5F00;
    localparam logic [DATA_W-1:0] ERR_MASK  = 16'h5800;
endpackage

// File: rtl/nic_csr_sel.sv
// Register index holder and write-strobe decoder.
// Assumes a single host write strobe that is qualified by a port select.
module nic_csr_sel #(
    parameter int CSR_CNT = 4,
    localparam int SEL_W  = $clog2(CSR_CNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_port,
    input  logic [SEL_W-1:0]   idx_d,
    output logic [SEL_W-1:0]   sel_q,
    output logic [CSR_CNT-1:0] wr_hit
);
    // Capture a new register index on an address-port write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (host_wr && host_port)
            sel_q <= idx_d;
    end

    // One write strobe per register
    for (genvar i = 0; i < CSR_CNT; i++) begin : g_hit
        assign wr_hit[i] = host_wr & ~host_port & (sel_q == SEL_W'(i));
    end
endmodule

// File: rtl/nic_csr_cfg.sv
// Configuration registers: the base address halves and the bus-control bits.
// Writes are accepted only while the caller asserts 'unlocked' (stop state).
module nic_csr_cfg #(
    parameter int LO_W   = 16,
    parameter int HI_W   = 8,
    parameter int BCTL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_bus,
    input  logic [LO_W-1:0]   lo_d,
    input  logic [HI_W-1:0]   hi_d,
    input  logic [BCTL_W-1:0] bus_d,
    output logic [LO_W-1:0]   lo_q,
    output logic [HI_W-1:0]   hi_q,
    output logic [BCTL_W-1:0] bus_q
);
    // Store the base address and the bus control while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            bus_q <= '0;
        end else if (unlocked) begin
            if (wr_lo)  lo_q  <= lo_d;
            if (wr_hi)  hi_q  <= hi_d;
            if (wr_bus) bus_q <= bus_d;
        end
    end
endmodule

// File: rtl/nic_csr_stat.sv
// Command/status register: sticky event flags (write-1-to-clear),
// command bits and the derived summary bits.
// Priority for a flag: stop clears, then event sets, then a write of 1 clears.
module nic_csr_stat
    import nic_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt_set,
    output logic [DATA_W-1:0] csr0,
    output logic              irq,
    output logic              init_req,
    output logic              stopped
);
    logic [DATA_W-1:0] flag_q, flag_d;
    logic ien_q, rxon_q, txon_q, stop_q, strt_q, init_q;
    logic stop_cmd;

    assign stop_cmd = wr_cmd & wdata[B_STOP];

    // Next value of each flag; positions without a flag are tied off
    for (genvar i = 0; i < DATA_W; i++) begin : g_flag
        if (FLAG_MASK[i]) begin : g_live
            assign flag_d[i] = stop_cmd   ? 1'b0 :
                               evt_set[i] ? 1'b1 :
                               (wr_cmd && wdata[i]) ? 1'b0 : flag_q[i];
        end else begin : g_tied
            assign flag_d[i] = 1'b0;
        end
    end

    // Hold the sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // Command bits: stop dominates, init and start leave the stop state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b1;
            ien_q  <= 1'b0;
            rxon_q <= 1'b0;
            txon_q <= 1'b0;
            strt_q <= 1'b0;
            init_q <= 1'b0;
        end else if (stop_cmd) begin
            stop_q <= 1'b1;
            ien_q  <= 1'b0;
            rxon_q <= 1'b0;
            txon_q <= 1'b0;
            strt_q <= 1'b0;
            init_q <= 1'b0;
        end else if (wr_cmd) begin
            ien_q <= wdata[B_IEN];
            if (wdata[B_INIT] || wdata[B_STRT]) stop_q <= 1'b0;
            if (wdata[B_INIT]) init_q <= 1'b1;
            if (wdata[B_STRT]) begin
                strt_q <= 1'b1;
                rxon_q <= 1'b1;
                txon_q <= 1'b1;
            end
        end
    end

    // One-cycle request to fetch the initialisation block
    always_ff @(posedge clk) begin
        if (!rst_n) init_req <= 1'b0;
        else        init_req <= wr_cmd & wdata[B_INIT] & ~wdata[B_STOP];
    end

    // Assemble the register image and the summary bits
    always_comb begin
        csr0         = flag_q;
        csr0[B_ERR]  = |(flag_q & ERR_MASK);
        csr0[B_INTR] = |flag_q;
        csr0[B_IEN]  = ien_q;
        csr0[B_RXON] = rxon_q;
        csr0[B_TXON] = txon_q;
        csr0[B_STOP] = stop_q;
        csr0[B_STRT] = strt_q;
        csr0[B_INIT] = init_q;
    end

    assign irq     = csr0[B_INTR] & ien_q;
    assign stopped = stop_q;
endmodule

// File: rtl/nic_csr_port.sv
// Host register port of a simple Ethernet controller.
// The address port picks a register and the data port reaches it.
// The assertion checker is bound at the end of the file.
module nic_csr_port
    import nic_csr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LO_W   = 16,
    parameter int BCTL_W = 3,
    localparam int HI_W  = ADDR_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_port,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] evt_set,
    output logic              irq,
    output logic [ADDR_W-1:0] init_base,
    output logic [BCTL_W-1:0] bus_ctl,
    output logic              rx_en,
    output logic              tx_en,
    output logic              init_req
);
    logic [SEL_W-1:0]   csr_sel;
    logic [CSR_CNT-1:0] wr_hit;
    logic [DATA_W-1:0]  csr0_q;
    logic               stopped;
    logic [LO_W-1:0]    base_lo;
    logic [HI_W-1:0]    base_hi;

    nic_csr_sel #(.CSR_CNT(CSR_CNT)) u_sel (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
        .idx_d(host_wdata[SEL_W-1:0]), .sel_q(csr_sel), .wr_hit(wr_hit)
    );

    nic_csr_stat u_stat (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_hit[CSR_CMD]), .wdata(host_wdata),
        .evt_set(evt_set), .csr0(csr0_q), .irq(irq), .init_req(init_req),
        .stopped(stopped)
    );

    nic_csr_cfg #(.LO_W(LO_W), .HI_W(HI_W), .BCTL_W(BCTL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .unlocked(stopped),
        .wr_lo(wr_hit[CSR_BASE_LO]), .wr_hi(wr_hit[CSR_BASE_HI]),
        .wr_bus(wr_hit[CSR_BUS]),
        .lo_d(host_wdata[LO_W-1:0]), .hi_d(host_wdata[HI_W-1:0]),
        .bus_d(host_wdata[BCTL_W-1:0]),
        .lo_q(base_lo), .hi_q(base_hi), .bus_q(bus_ctl)
    );

    // Read multiplexer over the four registers
    always_comb begin
        case (csr_sel)
            CSR_CMD:     host_rdata = csr0_q;
            CSR_BASE_LO: host_rdata = DATA_W'(base_lo);
            CSR_BASE_HI: host_rdata = DATA_W'(base_hi);
            default:     host_rdata = DATA_W'(bus_ctl);
        endcase
    end

    assign init_base = {base_hi, base_lo};
    assign rx_en     = csr0_q[B_RXON];
    assign tx_en     = csr0_q[B_TXON];
endmodule

// File: rtl/nic_csr_port_chk.sv
// Assertion checker for nic_csr_port, attached with bind.
module nic_csr_port_chk #(
    parameter int ADDR_W = 24,
    parameter int BCTL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_port,
    input logic [15:0]       host_wdata,
    input logic [15:0]       evt_set,
    input logic [1:0]        csr_sel,
    input logic [15:0]       csr0_q,
    input logic              irq,
    input logic              init_req,
    input logic [ADDR_W-1:0] init_base,
    input logic [BCTL_W-1:0] bus_ctl
);
    logic cmd_wr;
    assign cmd_wr = host_wr && !host_port && csr_sel == 2'd0;

    // R8: the interrupt needs both the enable and a pending flag
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr0_q[6] && csr0_q[7]));

    // R6: writing 0 over a set lost-frame flag keeps it set
    p_w1c_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !host_wdata[12] && !host_wdata[2] && csr0_q[12]) |=> csr0_q[12]);

    // R6: an event wins over a clearing write in the same cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !host_wdata[2] && evt_set[12]) |=> csr0_q[12]);

    // R9: stop clears flags and run state
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && host_wdata[2]) |=> ((csr0_q & 16'h5F73) == 16'h0 && csr0_q[2] && !irq));

    // R4: configuration is frozen while running
    p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_port && csr_sel != 2'd0 && !csr0_q[2])
            |=> ($stable(init_base) && $stable(bus_ctl)));

    // R10: the init request follows only a non-stop init write
    p_init_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |-> (csr0_q[0] && !csr0_q[2]));

    // R10: the init request lasts one cycle unless re-written
    p_init_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !host_wr) |=> !init_req);
endmodule

bind nic_csr_port nic_csr_port_chk #(.ADDR_W(ADDR_W), .BCTL_W(BCTL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
    .host_wdata(host_wdata), .evt_set(evt_set), .csr_sel(csr_sel),
    .csr0_q(csr0_q), .irq(irq), .init_req(init_req),
    .init_base(init_base), .bus_ctl(bus_ctl)
);

// File: tb/nic_csr_port_test.sv
// Self-checking bench: a vector table, then directed corner cases.
module nic_csr_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] evt_set = '0;
    logic [15:0] host_rdata;
    logic        irq, rx_en, tx_en, init_req;
    logic [23:0] init_base;
    logic [2:0]  bus_ctl;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nic_csr_port uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
        .irq(irq), .init_base(init_base), .bus_ctl(bus_ctl),
        .rx_en(rx_en), .tx_en(tx_en), .init_req(init_req)
    );

    typedef struct packed {
        logic        port;
        logic        wr;
        logic [15:0] wdata;
        logic [15:0] evt;
        logic [15:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b1, 16'h0001, 16'h0000, 16'h0000, 1'b0}, // R1 pick reg 1
        '{1'b0, 1'b1, 16'h1234, 16'h0000, 16'h1234, 1'b0}, // R2 low half
        '{1'b1, 1'b1, 16'h0002, 16'h0000, 16'h0000, 1'b0}, // R1 pick reg 2
        '{1'b0, 1'b1, 16'hFFAB, 16'h0000, 16'h00AB, 1'b0}, // R2 high byte only
        '{1'b1, 1'b1, 16'h0003, 16'h0000, 16'h0000, 1'b0}, // R1 pick reg 3
        '{1'b0, 1'b1, 16'h0005, 16'h0000, 16'h0005, 1'b0}, // R3
        '{1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R3 zero clears
        '{1'b0, 1'b1, 16'h0006, 16'h0000, 16'h0006, 1'b0}, // R3
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0004, 1'b0}, // R1 back to reg 0
        '{1'b0, 1'b1, 16'h0043, 16'h0000, 16'h0073, 1'b0}, // R10 R11 init+start+enable
        '{1'b0, 1'b0, 16'h0000, 16'h0100, 16'h01F3, 1'b1}, // R5 R8 init done
        '{1'b0, 1'b0, 16'h0000, 16'h1000, 16'h91F3, 1'b1}, // R5 R7 lost frame
        '{1'b0, 1'b1, 16'h0140, 16'h0000, 16'h90F3, 1'b1}, // R6 clear init done
        '{1'b0, 1'b1, 16'h0040, 16'h0000, 16'h90F3, 1'b1}, // R6 zero no effect
        '{1'b0, 1'b1, 16'h1040, 16'h0000, 16'h0073, 1'b0}, // R6 R8 clear drops irq
        '{1'b0, 1'b0, 16'h0000, 16'h0400, 16'h04F3, 1'b1}, // R5 R7 no error bit
        '{1'b0, 1'b1, 16'h0000, 16'h0000, 16'h04B3, 1'b0}, // R8 enable off gates
        '{1'b0, 1'b1, 16'h0040, 16'h0000, 16'h04F3, 1'b1}, // R8 enable back on
        '{1'b0, 1'b0, 16'h0000, 16'h0002, 16'h04F3, 1'b1}, // R5 non-flag event ignored
        '{1'b0, 1'b0, 16'h0000, 16'h4000, 16'hC4F3, 1'b1}, // R5 R7 babble
        '{1'b0, 1'b1, 16'h0404, 16'h0000, 16'h0004, 1'b0}  // R9 stop clears all
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One cycle of stimulus; returns at the following falling edge
    task automatic drive(input logic port, input logic wr, input logic [15:0] wd,
                         input logic [15:0] ev);
        @(negedge clk);
        host_port = port; host_wr = wr; host_wdata = wd; evt_set = ev;
        @(negedge clk);
        host_port = 1'b0; host_wr = 1'b0; host_wdata = '0; evt_set = '0;
    endtask

    // Watchdog: a hung run is one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset reg0", host_rdata, 32'h0004);
        chk("R12 reset irq", irq, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].port, TBL[i].wr, TBL[i].wdata, TBL[i].evt);
            chk($sformatf("R1-table vec %0d rdata", i), host_rdata, TBL[i].exp);
            chk($sformatf("R8 table vec %0d irq", i), irq, TBL[i].exp_irq);
        end

        chk("R2 init_base", init_base, 32'hAB1234);
        chk("R3 bus_ctl", bus_ctl, 3'd6);

        // R11 start leaves stop, turns on both directions
        drive(1'b0, 1'b1, 16'h0002, 16'h0);
        chk("R11 start word", host_rdata, 32'h0032);
        chk("R11 rx_en", rx_en, 1);
        chk("R11 tx_en", tx_en, 1);
        chk("R11 no init_req", init_req, 0);

        // R4 configuration write ignored while running
        drive(1'b1, 1'b1, 16'h0001, 16'h0);
        drive(1'b0, 1'b1, 16'h5555, 16'h0);
        chk("R4 reg1 unchanged", host_rdata, 32'h1234);
        chk("R4 init_base unchanged", init_base, 32'hAB1234);

        // R6 event and clear in the same cycle: set wins
        drive(1'b1, 1'b1, 16'h0000, 16'h0);
        drive(1'b0, 1'b1, 16'h1000, 16'h1000);
        chk("R6 set wins", host_rdata, 32'h90B2);
        chk("R8 no irq with enable off", irq, 0);

        // R9 stop beats a same-cycle event
        drive(1'b0, 1'b1, 16'h0004, 16'h0800);
        chk("R9 stop beats event", host_rdata, 32'h0004);
        chk("R9 rx_en off", rx_en, 0);

        // R10 init pulse
        drive(1'b0, 1'b1, 16'h0001, 16'h0);
        chk("R10 init word", host_rdata, 32'h0001);
        chk("R10 init_req high", init_req, 1);
        @(negedge clk);
        chk("R10 init_req one cycle", init_req, 0);

        // R12 reset mid-run
        drive(1'b1, 1'b1, 16'h0003, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset reg0 after run", host_rdata, 32'h0004);
        chk("R12 reset base", init_base, 0);
        chk("R12 reset bus", bus_ctl, 0);
        chk("R12 reset init_req", init_req, 0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule